// File: doc/BRIEF.md
# SPI Receive Descriptor Ring Engine

This block takes bytes from an SPI receiver and stores them in memory buffers. The buffers are described by a ring of 8-byte descriptors that sit in a shared single-port RAM. Software fills in each descriptor and sets its ownership bit to hand it to the engine. The engine reads the descriptor, writes the incoming bytes one at a time into the buffer, and then closes the descriptor. On close it writes the byte count and the status flags, posts an event, and moves to the next descriptor. When the closed descriptor carries the wrap flag, it returns to the ring base instead.

A descriptor stays with the engine after closing when continuous mode is set and the link runs as master. The same buffer is then overwritten each time the ring comes back to it, with no action from software. A byte that arrives when no buffer can take it is discarded. The loss is reported in the next descriptor that closes and in an event bit. A multi-master fault aborts the current buffer.

The memory port is 16 bits wide and synchronous. Read data appears one cycle after the request.

Top module: `spi_rx_ring`

## Requirements
- R1: While reset is held and after its release, `evt_o` and `irq_o` are 0, and no memory write is issued before a descriptor has been fetched.
- R2: A descriptor at byte address D holds the status word at D+0, the length at D+2, the pointer high half at D+4 and the low half at D+6. Memory words are 16 bits. The byte at an even address sits on bits 15:8 with `mem_be_o`=2'b10, and the byte at an odd address sits on bits 7:0 with 2'b01. Received byte i goes to pointer+i.
- R3: Status bit 15 marks the descriptor as owned by the engine. A descriptor with bit 15 clear is never written to. The engine keeps re-reading its status until bit 15 is set.
- R4: When the byte count reaches `max_len_i`, the buffer closes, and `max_len_i` is written to D+2.
- R5: A pulse on `rx_eof_i` closes the buffer. The count received so far is written to D+2, and status bit 11 is set.
- R6: A pulse on `mm_err_i` while a buffer is receiving closes it with status bit 0 set and the count received so far. A byte offered in the same cycle is discarded.
- R7: Closing clears bit 15 of the written status, unless bit 9 (continuous) is set and `master_mode_i` is 1. In that case bit 15 stays set and the descriptor is reused when the ring reaches it again.
- R8: When bit 13 of the closed descriptor is set, the next descriptor is at `ring_base_i`. Otherwise it is at D+8.
- R9: When bit 12 of the closed descriptor is set, `evt_o[0]` becomes 1.
- R10: A byte offered while no buffer is receiving is dropped and sets `evt_o[1]`. Status bit 1 is then set in the next descriptor written on close, and is cleared for the closes after it.
- R11: Writing 1 to a bit of `evt_clr_i` clears that event bit. `irq_o` is the OR of the event bits that are set and unmasked in `evt_mask_i`.
- R12: The closing status write keeps bits 14:12, 10:2 and 9 exactly as they were fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_base_i | input | AW | Byte address of the first descriptor |
| max_len_i | input | LW | Maximum bytes per buffer |
| master_mode_i | input | 1 | Link runs as master; enables continuous mode |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_eof_i | input | 1 | End-of-transfer strobe |
| mm_err_i | input | 1 | Multi-master fault strobe |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address (word aligned) |
| mem_wdata_o | output | 16 | Memory write data |
| mem_be_o | output | 2 | Memory byte enables |
| mem_rdata_i | input | 16 | Memory read data, one cycle after request |
| evt_clr_i | input | 2 | Write-one-to-clear event strobes |
| evt_mask_i | input | 2 | Interrupt enables per event |
| evt_o | output | 2 | Event bits: 0 buffer done, 1 byte dropped |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- `max_len_i` is at least 1 and does not change while a buffer is open.
- `ring_base_i` is 8-byte aligned.
- The memory returns read data exactly one cycle after a read request.

The stimulus sets `max_len_i` once and places the ring at address 0. It waits long enough after each close for the next descriptor to be fetched before offering bytes. The one exception is a deliberate byte sent while the engine is polling an unowned descriptor. Descriptors are only rewritten while their ownership bit is clear.

// File: rtl/spi_rx_ring_pkg.sv
package spi_rx_ring_pkg;
  localparam int DW      = 16;
  localparam int EVW     = 2;
  localparam int B_OWN   = 15;
  localparam int B_WRAP  = 13;
  localparam int B_INT   = 12;
  localparam int B_LAST  = 11;
  localparam int B_CONT  = 9;
  localparam int B_OVR   = 1;
  localparam int B_MME   = 0;
  localparam int OFF_ST  = 0;
  localparam int OFF_LEN = 2;
  localparam int OFF_PH  = 4;
  localparam int OFF_PL  = 6;
  localparam int DSTEP   = 8;
  localparam logic [DW-1:0] KEEP_MASK =
    ~((DW'(1) << B_OWN) | (DW'(1) << B_LAST) | (DW'(1) << B_OVR) | (DW'(1) << B_MME));

  typedef enum logic [3:0] {
    S_INIT, S_RD_ST, S_CK_ST, S_RD_PH, S_RD_PL, S_CP_PL, S_RECV, S_WR_LEN, S_WR_ST
  } rx_state_e;
endpackage

// File: rtl/rxr_cursor.sv
module rxr_cursor #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] cur_o
);
  import spi_rx_ring_pkg::*;

  logic [AW-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cur_q <= '0;
    else if (load_i || (adv_i && wrap_i)) cur_q <= base_i;
    else if (adv_i)                   cur_q <= cur_q + AW'(DSTEP);
  end

  assign cur_o = cur_q;

  assert_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wrap_i && !load_i) |=> (cur_q == $past(cur_q) + AW'(DSTEP)));
  assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_i) |=> (cur_q == $past(base_i)));
endmodule

// File: rtl/rxr_events.sv
module rxr_events #(
  parameter int EW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [EW-1:0] set_i,
  input  logic [EW-1:0] clr_i,
  input  logic [EW-1:0] mask_i,
  output logic [EW-1:0] evt_o,
  output logic          irq_o
);
  logic [EW-1:0] evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (evt_q & ~clr_i) | set_i;
  end

  assign evt_o = evt_q;
  assign irq_o = |(evt_q & mask_i);

  assert_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[0] |=> evt_q[0]);
  assert_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((evt_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] cur_i,
  input  logic [LW-1:0] max_len_i,
  input  logic          master_mode_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_eof_i,
  input  logic          mm_err_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  output logic [1:0]    mem_be_o,
  input  logic [15:0]   mem_rdata_i,
  output logic          load_o,
  output logic          adv_o,
  output logic          wrap_o,
  output logic          done_o,
  output logic          drop_o
);
  import spi_rx_ring_pkg::*;

  rx_state_e     state_q, state_d;
  logic [DW-1:0] st_q, st_d;
  logic [31:0]   ptr_q, ptr_d;
  logic [LW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          fin_l_q, fin_l_d, fin_me_q, fin_me_d, ov_q;
  logic          keep_own;
  logic [AW-1:0] byte_addr;
  logic [DW-1:0] close_st;

  assign cnt_inc   = cnt_q + LW'(1);
  assign byte_addr = AW'(ptr_q + 32'(cnt_q));
  assign keep_own  = st_q[B_CONT] && master_mode_i;
  assign close_st  = (st_q & KEEP_MASK) | (DW'(keep_own) << B_OWN) |
                     (DW'(fin_l_q) << B_LAST) | (DW'(ov_q) << B_OVR) |
                     (DW'(fin_me_q) << B_MME);
  assign drop_o    = rx_valid_i && (state_q != S_RECV);

  always_comb begin
    state_d = state_q; st_d = st_q; ptr_d = ptr_q; cnt_d = cnt_q;
    fin_l_d = fin_l_q; fin_me_d = fin_me_q;
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = cur_i;
    mem_wdata_o = '0; mem_be_o = 2'b11;
    load_o = 1'b0; adv_o = 1'b0; wrap_o = 1'b0; done_o = 1'b0;
    unique case (state_q)
      S_INIT: begin
        load_o  = 1'b1;
        state_d = S_RD_ST;
      end
      S_RD_ST: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_i + AW'(OFF_ST);
        state_d    = S_CK_ST;
      end
      S_CK_ST: begin
        st_d    = mem_rdata_i;
        state_d = mem_rdata_i[B_OWN] ? S_RD_PH : S_RD_ST;
      end
      S_RD_PH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_i + AW'(OFF_PH);
        state_d    = S_RD_PL;
      end
      S_RD_PL: begin
        ptr_d[31:16] = mem_rdata_i;
        mem_req_o    = 1'b1;
        mem_addr_o   = cur_i + AW'(OFF_PL);
        state_d      = S_CP_PL;
      end
      S_CP_PL: begin
        ptr_d[15:0] = mem_rdata_i;
        cnt_d       = '0;
        fin_l_d     = 1'b0;
        fin_me_d    = 1'b0;
        state_d     = S_RECV;
      end
      S_RECV: begin
        if (mm_err_i) begin
          fin_me_d = 1'b1;
          fin_l_d  = 1'b0;
          state_d  = S_WR_LEN;
        end else begin
          if (rx_valid_i) begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = {byte_addr[AW-1:1], 1'b0};
            mem_wdata_o = {rx_data_i, rx_data_i};
            mem_be_o    = byte_addr[0] ? 2'b01 : 2'b10;
            cnt_d       = cnt_inc;
          end
          if (rx_eof_i || (rx_valid_i && cnt_inc == max_len_i)) begin
            fin_l_d = rx_eof_i;
            state_d = S_WR_LEN;
          end
        end
      end
      S_WR_LEN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_i + AW'(OFF_LEN);
        mem_wdata_o = 16'(cnt_q);
        state_d     = S_WR_ST;
      end
      S_WR_ST: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_i + AW'(OFF_ST);
        mem_wdata_o = close_st;
        adv_o       = 1'b1;
        wrap_o      = st_q[B_WRAP];
        done_o      = st_q[B_INT];
        state_d     = S_RD_ST;
      end
      default: state_d = S_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_INIT; st_q <= '0; ptr_q <= '0; cnt_q <= '0;
      fin_l_q <= 1'b0; fin_me_q <= 1'b0; ov_q <= 1'b0;
    end else begin
      state_q  <= state_d; st_q <= st_d; ptr_q <= ptr_d; cnt_q <= cnt_d;
      fin_l_q  <= fin_l_d; fin_me_q <= fin_me_d;
      ov_q     <= (ov_q && state_q != S_WR_ST) || drop_o;
    end
  end

  assert_owned_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && state_q == S_RECV) |-> st_q[B_OWN]);
  assert_len_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WR_LEN) |-> (mem_wdata_o <= 16'(max_len_i)));
  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WR_ST && !(st_q[B_CONT] && master_mode_i)) |-> !mem_wdata_o[B_OWN]);
  assert_ov_report_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WR_ST && ov_q) |-> mem_wdata_o[B_OVR]);
  assert_ov_drain_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WR_ST && !drop_o) |=> !ov_q);
endmodule

// File: rtl/spi_rx_ring.sv
module spi_rx_ring #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ring_base_i,
  input  logic [LW-1:0] max_len_i,
  input  logic          master_mode_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_eof_i,
  input  logic          mm_err_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  output logic [1:0]    mem_be_o,
  input  logic [15:0]   mem_rdata_i,
  input  logic [1:0]    evt_clr_i,
  input  logic [1:0]    evt_mask_i,
  output logic [1:0]    evt_o,
  output logic          irq_o
);
  import spi_rx_ring_pkg::*;

  logic [AW-1:0] cur;
  logic load, adv, wrap, done, drop;

  rxr_cursor #(.AW(AW)) u_cursor (
    .clk_i, .rst_ni, .base_i(ring_base_i), .load_i(load), .adv_i(adv),
    .wrap_i(wrap), .cur_o(cur)
  );

  rxr_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk_i, .rst_ni, .cur_i(cur), .max_len_i, .master_mode_i,
    .rx_valid_i, .rx_data_i, .rx_eof_i, .mm_err_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_be_o, .mem_rdata_i,
    .load_o(load), .adv_o(adv), .wrap_o(wrap), .done_o(done), .drop_o(drop)
  );

  rxr_events #(.EW(EVW)) u_events (
    .clk_i, .rst_ni, .set_i({drop, done}), .clr_i(evt_clr_i),
    .mask_i(evt_mask_i), .evt_o, .irq_o
  );
endmodule

// File: tb/sim_spi_rx_ring.sv
`timescale 1ns/1ps
module sim_spi_rx_ring;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] ring_base = 16'h0000, max_len = 16'd4;
  logic master = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0, mm_err = 1'b0;
  logic [7:0] rx_data = '0;
  logic mem_req, mem_we, irq;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0] mem_be, evt, evt_clr = '0, evt_mask = 2'b01;

  always #5 clk = ~clk;

  spi_rx_ring u0 (
    .clk_i(clk), .rst_ni(rst_n), .ring_base_i(ring_base), .max_len_i(max_len),
    .master_mode_i(master), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_eof_i(rx_eof), .mm_err_i(mm_err), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .mem_rdata_i(mem_rdata), .evt_clr_i(evt_clr), .evt_mask_i(evt_mask),
    .evt_o(evt), .irq_o(irq)
  );

  logic [15:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      if (mem_be[1]) mem[mem_addr[8:1]][15:8] = mem_wdata[15:8];
      if (mem_be[0]) mem[mem_addr[8:1]][7:0]  = mem_wdata[7:0];
    end else if (mem_req) mem_rdata <= mem[mem_addr[8:1]];
  end

  int nchk = 0, nerr = 0;
  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct { logic [15:0] a; logic [15:0] st; logic [15:0] len; string tag; } close_t;
  close_t dq[$];
  logic [23:0] bq[$];

  // monitor: mid-cycle sampling of memory writes
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we) begin
      if (mem_addr < 16'h0100) begin
        if (dq.size() == 0) chk(0, "R3 unexpected descriptor write", int'(mem_addr), 0);
        else if (mem_addr[2:0] == 3'd2) begin
          chk(mem_addr == dq[0].a + 16'd2, {dq[0].tag, " R2 length address"}, int'(mem_addr), int'(dq[0].a + 16'd2));
          chk(mem_wdata == dq[0].len, {dq[0].tag, " length"}, int'(mem_wdata), int'(dq[0].len));
        end else begin
          chk(mem_addr == dq[0].a, {dq[0].tag, " R8 status address"}, int'(mem_addr), int'(dq[0].a));
          chk(mem_wdata == dq[0].st, {dq[0].tag, " status"}, int'(mem_wdata), int'(dq[0].st));
          void'(dq.pop_front());
        end
      end else begin
        if (bq.size() == 0) chk(0, "R10 unexpected byte write", int'(mem_addr), 0);
        else begin
          logic [15:0] ea;
          logic [7:0] eb;
          {ea, eb} = bq.pop_front();
          chk(mem_addr == {ea[15:1], 1'b0}, "R2 byte word address", int'(mem_addr), int'({ea[15:1], 1'b0}));
          chk(mem_be == (ea[0] ? 2'b01 : 2'b10), "R2 byte lane", int'(mem_be), ea[0] ? 1 : 2);
          chk((ea[0] ? mem_wdata[7:0] : mem_wdata[15:8]) == eb, "R2 byte data",
              int'(ea[0] ? mem_wdata[7:0] : mem_wdata[15:8]), int'(eb));
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(logic [7:0] b, logic [15:0] a, bit exp);
    if (exp) bq.push_back({a, b});
    rx_valid = 1'b1; rx_data = b; tick(1);
    rx_valid = 1'b0; tick(1);
  endtask

  task automatic frame(int n, logic [15:0] buf_a, logic [7:0] seed);
    for (int i = 0; i < n; i++) send(seed + 8'(i), buf_a + 16'(i), 1'b1);
  endtask

  task automatic pulse_eof();  rx_eof = 1'b1; tick(1); rx_eof = 1'b0; tick(1); endtask
  task automatic pulse_mme();  mm_err = 1'b1; tick(1); mm_err = 1'b0; tick(1); endtask
  task automatic clr_all();    evt_clr = 2'b11; tick(1); evt_clr = 2'b00; tick(1); endtask

  task automatic expect_close(logic [15:0] a, logic [15:0] st, logic [15:0] len, string tag);
    close_t c;
    c.a = a; c.st = st; c.len = len; c.tag = tag;
    dq.push_back(c);
  endtask

  task automatic set_desc(int k, logic [15:0] st, logic [15:0] p);
    mem[k*4] = st; mem[k*4+1] = 16'h0; mem[k*4+2] = 16'h0; mem[k*4+3] = p;
  endtask

  // status bits: own 8000 wrap 2000 int 1000 last 0800 cont 0200 ovr 0002 mme 0001
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    set_desc(0, 16'h9000, 16'h0100);
    set_desc(1, 16'h9020, 16'h0140);
    set_desc(2, 16'hA000, 16'h0180);
    tick(2);
    chk(evt == 2'b00 && irq == 1'b0, "R1 events in reset", int'({irq, evt}), 0);
    chk(mem_we == 1'b0, "R1 no write in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    tick(1);
    chk(evt == 2'b00 && irq == 1'b0, "R1 events after reset", int'({irq, evt}), 0);
    tick(10);

    expect_close(16'h0000, 16'h1000, 16'd4, "R4 full close");
    frame(4, 16'h0100, 8'hA0);
    tick(6);
    chk(evt == 2'b01, "R9 done event", int'(evt), 1);
    chk(irq == 1'b1, "R11 irq unmasked", int'(irq), 1);
    clr_all();
    chk(evt == 2'b00 && irq == 1'b0, "R11 w1c clear", int'({irq, evt}), 0);
    tick(8);

    expect_close(16'h0008, 16'h1820, 16'd2, "R5 R12 eof close");
    frame(2, 16'h0140, 8'hB0);
    pulse_eof();
    tick(6);
    clr_all();
    tick(8);

    expect_close(16'h0010, 16'h2001, 16'd1, "R6 abort close");
    frame(1, 16'h0180, 8'hC0);
    pulse_mme();
    tick(6);
    chk(evt == 2'b00, "R9 no event without int bit", int'(evt), 0);
    tick(8);

    // ring wrapped to descriptor 0 which software has not returned
    send(8'hEE, 16'h0, 1'b0);
    tick(4);
    chk(evt == 2'b10, "R10 drop event", int'(evt), 2);
    chk(irq == 1'b0, "R11 masked event no irq", int'(irq), 0);
    chk(mem[0] == 16'h1000, "R3 unowned descriptor untouched", int'(mem[0]), 16'h1000);
    clr_all();
    mem[0] = 16'h9200;  // continuous requested, slave mode
    tick(12);

    expect_close(16'h0000, 16'h1A02, 16'd3, "R7 R10 slave cont ov");
    frame(3, 16'h0100, 8'hD0);
    pulse_eof();
    tick(6);
    chk(evt == 2'b01, "R9 done event again", int'(evt), 1);
    clr_all();
    master = 1'b1;
    mem[4] = 16'h8200;
    tick(12);

    expect_close(16'h0008, 16'h8200, 16'd4, "R7 cont keeps own");
    frame(4, 16'h0140, 8'h10);
    tick(6);
    mem[8] = 16'hB000;
    tick(12);

    expect_close(16'h0010, 16'h3000, 16'd4, "R8 wrap close");
    frame(4, 16'h0180, 8'h20);
    tick(6);
    clr_all();
    mem[0] = 16'h8000;
    tick(12);

    expect_close(16'h0000, 16'h0800, 16'd1, "R8 R10 after wrap ov cleared");
    frame(1, 16'h0100, 8'h30);
    pulse_eof();
    tick(14);

    expect_close(16'h0008, 16'h8A00, 16'd2, "R7 reuse cont buffer");
    frame(2, 16'h0140, 8'h40);
    pulse_eof();
    tick(10);

    chk(mem[16'h0140 >> 1] == 16'h4041, "R7 buffer overwritten", int'(mem[16'h0140 >> 1]), 16'h4041);
    chk(mem[16'h0142 >> 1] == 16'h1213, "R7 old tail kept", int'(mem[16'h0142 >> 1]), 16'h1213);
    chk(dq.size() == 0, "R4 all closes seen", dq.size(), 0);
    chk(bq.size() == 0, "R2 all bytes seen", bq.size(), 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule